// File: doc/BRIEF.md
# In-Order Read Completion Reorder Buffer

This block sits between a read-request issuer and a user that consumes read data. Each read request covers one 4 KB block: 256 consecutive beats of 128-bit data. When a request is accepted, the buffer hands back a slot tag. The tag travels with the request to the far side, and the completion beats come back carrying that tag. Completions for different requests may arrive in any order and may be interleaved beat by beat. Within one slot the beats arrive in order.

The buffer keeps one 4 KB area per slot. It counts the beats written into each slot and marks the slot complete after the 256th beat. It streams complete blocks to the user strictly in the order the requests were accepted. The number of slots is 2^`SLOT_BITS`; the intended range of `SLOT_BITS` is 4 to 8, which gives 64 KB to 1 MB of storage. When every slot is taken, request-ready drops. The user can hold back the output stream with a pause input. The pause takes effect after a fixed lag, and every beat shown with valid high counts as delivered.

Top module: `rd_reorder_buf`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1, `rd_valid` is 0 and `req_tag` is 0.
- R2: Accepted requests (`req_valid` and `req_ready` high at the same clock edge) receive tags 0, 1, 2, … in acceptance order, modulo the slot count. The tag is shown on `req_tag` in the cycle the request is accepted.
- R3: `req_ready` is 0 exactly when the slot count of requests are accepted and not yet fully delivered. While it is 0 no request is taken and `req_tag` holds its value. It returns to 1 in the cycle after the last beat of the oldest block is shown.
- R4: Completion beats for one tag are stored as beats 0 to 255 in their order of arrival. Blocks may complete in any order, and their beats may be interleaved.
- R5: Blocks leave on `rd_data` in the order their requests were accepted, and each block carries the data written to its slot.
- R6: Inside a block, `rd_valid` stays 1 from beat to beat unless `rd_pause` was 1 two cycles before.
- R7: If `rd_pause` is 1 in a cycle, `rd_valid` is 0 two cycles later. Pausing neither drops nor repeats a beat, and clearing pause resumes with the next beat.
- R8: After the last beat of a block, `rd_valid` is 0 for at least one cycle.
- R9: No beat of a block is shown before all 256 of its beats have been written, even if younger blocks are complete.
- R10: Completion beats sent to a slot whose block is already complete are ignored and do not alter that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | A free slot exists; request is taken when both are high |
| req_tag | output | SLOT_BITS | Slot tag given to the request accepted this cycle |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | SLOT_BITS | Slot the completion beat belongs to |
| cpl_data | input | DATA_W | Completion beat data |
| rd_pause | input | 1 | User asks the output stream to stop |
| rd_valid | output | 1 | Output beat present and delivered |
| rd_data | output | DATA_W | Output beat data |

## Verification
A request's tag is due in the cycle it is accepted. `req_ready` reflects an accept or a block release one cycle later. The first beat of a block appears no earlier than the third cycle after its last completion beat, and output valid falls in the second cycle after pause is seen. The bench samples every output half a cycle after the active edge. It keeps a two-deep history of the pause input and a running count of accepted and delivered blocks, so each check compares against the cycle in which the result is due. Random completion orders with random beat interleaving and random pause bursts are mixed with directed cases: a full buffer, a complete younger block waiting behind an incomplete older one, and stray beats sent to a complete slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_RUN  = 2'd1,
    DR_WAIT = 2'd2
  } drain_state_t;
endpackage

// File: rtl/rob_slot_alloc.sv
// Round-robin slot allocation and release, with occupancy and ready.
module rob_slot_alloc #(
  parameter int SLOT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 release_i,
  output logic                 req_ready,
  output logic [SLOT_BITS-1:0] req_tag,
  output logic [SLOT_BITS-1:0] head_slot,
  output logic [SLOT_BITS:0]   occupancy
);
  localparam int SLOTS = 1 << SLOT_BITS;

  logic [SLOT_BITS-1:0] alloc_ptr_q, head_ptr_q;
  logic [SLOT_BITS:0]   occ_q, occ_d;
  logic                 full_q;
  logic                 accept;

  assign accept = req_valid & ~full_q;
  assign occ_d  = occ_q + (SLOT_BITS+1)'(accept) - (SLOT_BITS+1)'(release_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_ptr_q <= '0;
      head_ptr_q  <= '0;
      occ_q       <= '0;
      full_q      <= 1'b0;
    end else begin
      if (accept)    alloc_ptr_q <= alloc_ptr_q + 1'b1;
      if (release_i) head_ptr_q  <= head_ptr_q + 1'b1;
      occ_q  <= occ_d;
      full_q <= (occ_d == (SLOT_BITS+1)'(SLOTS));
    end
  end

  assign req_ready = ~full_q;
  assign req_tag   = alloc_ptr_q;
  assign head_slot = head_ptr_q;
  assign occupancy = occ_q;
endmodule

// File: rtl/rob_fill_track.sv
// Per-slot beat counters and completion flags; builds the write address.
module rob_fill_track #(
  parameter int SLOT_BITS = 4,
  parameter int BEAT_BITS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cpl_valid,
  input  logic [SLOT_BITS-1:0]           cpl_tag,
  input  logic                           clear_i,
  input  logic [SLOT_BITS-1:0]           clear_slot,
  output logic                           wr_en,
  output logic [SLOT_BITS+BEAT_BITS-1:0] wr_addr,
  output logic [(1<<SLOT_BITS)-1:0]      slot_done
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam logic [BEAT_BITS-1:0] LAST_BEAT = '1;

  logic [BEAT_BITS-1:0] cnt_q [SLOTS];
  logic [SLOTS-1:0]     done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      for (int s = 0; s < SLOTS; s++) cnt_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (cpl_valid && (cpl_tag == SLOT_BITS'(s)) && !done_q[s]) begin
          cnt_q[s] <= cnt_q[s] + 1'b1;
          if (cnt_q[s] == LAST_BEAT) done_q[s] <= 1'b1;
        end else if (clear_i && (clear_slot == SLOT_BITS'(s))) begin
          done_q[s] <= 1'b0;
        end
      end
    end
  end

  assign wr_en     = cpl_valid & ~done_q[cpl_tag];
  assign wr_addr   = {cpl_tag, cnt_q[cpl_tag]};
  assign slot_done = done_q;
endmodule

// File: rtl/rob_store.sv
// Simple dual-port storage with registered read, shaped for block RAM.
module rob_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rob_drain.sv
// Head-slot streaming: issue, RAM read stage, output register, release.
module rob_drain
  import rob_pkg::*;
#(
  parameter int SLOT_BITS = 4,
  parameter int BEAT_BITS = 8,
  parameter int DATA_W    = 128
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SLOT_BITS-1:0]           head_slot,
  input  logic                           head_done,
  input  logic                           rd_pause,
  input  logic [DATA_W-1:0]              ram_rdata,
  output logic                           ram_re,
  output logic [SLOT_BITS+BEAT_BITS-1:0] ram_raddr,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_last,
  output logic                           release_o
);
  localparam logic [BEAT_BITS-1:0] LAST_BEAT = '1;

  drain_state_t         state_q;
  logic [BEAT_BITS-1:0] beat_q;
  logic                 issue, issue_last;
  logic                 s1_v_q, s1_last_q;
  logic                 out_v_q, out_last_q;
  logic [DATA_W-1:0]    out_data_q;

  assign issue      = (state_q == DR_RUN) && !rd_pause;
  assign issue_last = issue && (beat_q == LAST_BEAT);
  assign ram_re     = issue;
  assign ram_raddr  = {head_slot, beat_q};
  assign release_o  = out_v_q & out_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= DR_IDLE;
      beat_q     <= '0;
      s1_v_q     <= 1'b0;
      s1_last_q  <= 1'b0;
      out_v_q    <= 1'b0;
      out_last_q <= 1'b0;
    end else begin
      case (state_q)
        DR_IDLE: if (head_done) begin
          state_q <= DR_RUN;
          beat_q  <= '0;
        end
        DR_RUN: if (issue) begin
          beat_q <= beat_q + 1'b1;
          if (issue_last) state_q <= DR_WAIT;
        end
        DR_WAIT: if (release_o) state_q <= DR_IDLE;
        default: state_q <= DR_IDLE;
      endcase
      s1_v_q     <= issue;
      s1_last_q  <= issue_last;
      out_v_q    <= s1_v_q;
      out_last_q <= s1_v_q & s1_last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v_q) out_data_q <= ram_rdata;
  end

  assign rd_valid = out_v_q;
  assign rd_data  = out_data_q;
  assign rd_last  = out_last_q;
endmodule

// File: rtl/rd_reorder_buf.sv
// Top: tagged out-of-order 4 KB completions in, request-ordered stream out.
module rd_reorder_buf #(
  parameter int SLOT_BITS = 4,
  parameter int BEAT_BITS = 8,
  parameter int DATA_W    = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic [SLOT_BITS-1:0] req_tag,
  input  logic                 cpl_valid,
  input  logic [SLOT_BITS-1:0] cpl_tag,
  input  logic [DATA_W-1:0]    cpl_data,
  input  logic                 rd_pause,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int SLOTS  = 1 << SLOT_BITS;
  localparam int ADDR_W = SLOT_BITS + BEAT_BITS;

  logic                 release_pulse;
  logic [SLOT_BITS-1:0] head_slot;
  logic [SLOT_BITS:0]   occupancy;
  logic                 wr_en, ram_re;
  logic [ADDR_W-1:0]    wr_addr, ram_raddr;
  logic [SLOTS-1:0]     slot_done;
  logic                 head_done;
  logic [DATA_W-1:0]    ram_rdata;
  logic                 out_last;

  rob_slot_alloc #(.SLOT_BITS(SLOT_BITS)) u_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .release_i(release_pulse),
    .req_ready(req_ready), .req_tag(req_tag), .head_slot(head_slot),
    .occupancy(occupancy)
  );

  rob_fill_track #(.SLOT_BITS(SLOT_BITS), .BEAT_BITS(BEAT_BITS)) u_fill (
    .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .clear_i(release_pulse), .clear_slot(head_slot),
    .wr_en(wr_en), .wr_addr(wr_addr), .slot_done(slot_done)
  );

  assign head_done = slot_done[head_slot];

  rob_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(cpl_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  rob_drain #(.SLOT_BITS(SLOT_BITS), .BEAT_BITS(BEAT_BITS), .DATA_W(DATA_W)) u_drain (
    .clk(clk), .rst(rst), .head_slot(head_slot), .head_done(head_done),
    .rd_pause(rd_pause), .ram_rdata(ram_rdata), .ram_re(ram_re),
    .ram_raddr(ram_raddr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(out_last), .release_o(release_pulse)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int SLOT_BITS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic [SLOT_BITS-1:0] req_tag,
  input logic                 rd_pause,
  input logic                 rd_valid,
  input logic                 rd_last,
  input logic                 release_pulse,
  input logic                 head_done,
  input logic [SLOT_BITS:0]   occupancy
);
  localparam int SLOTS = 1 << SLOT_BITS;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rd_valid && req_ready && req_tag == '0));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(req_tag));

  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= (SLOT_BITS+1)'(SLOTS));

  // R7
  pause_lag_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pause |-> ##2 !rd_valid);

  // R6
  stream_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last && !$past(rd_pause)) |=> rd_valid);

  // R8
  block_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_last) |=> !rd_valid);

  // R9
  release_done_chk: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> head_done);
endmodule

bind rd_reorder_buf rob_checker #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .req_tag(req_tag),
  .rd_pause(rd_pause), .rd_valid(rd_valid), .rd_last(out_last),
  .release_pulse(release_pulse), .head_done(head_done), .occupancy(occupancy)
);

// File: tb/test_rd_reorder_buf.sv
module test_rd_reorder_buf;
  localparam int SLOT_BITS = 4;
  localparam int BEAT_BITS = 8;
  localparam int DATA_W    = 128;
  localparam int SLOTS     = 1 << SLOT_BITS;
  localparam int BEATS     = 1 << BEAT_BITS;
  localparam int NREQ      = 48;
  localparam int WDOG      = 150000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [SLOT_BITS-1:0] req_tag;
  logic                 cpl_valid = 1'b0;
  logic [SLOT_BITS-1:0] cpl_tag = '0;
  logic [DATA_W-1:0]    cpl_data = '0;
  logic                 rd_pause = 1'b0;
  logic                 rd_valid;
  logic [DATA_W-1:0]    rd_data;

  rd_reorder_buf #(.SLOT_BITS(SLOT_BITS), .BEAT_BITS(BEAT_BITS), .DATA_W(DATA_W)) i_rd_reorder_buf (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_data(cpl_data), .rd_pause(rd_pause), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int acc_cnt = 0, del_cnt = 0, cyc = 0;
  int sent [NREQ];
  bit all_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] beat_word(input int s, input int b);
    return {32'(s), 32'(b), 32'(s * 7919) ^ 32'(b * 31), 32'hA5A50000 ^ 32'(b)};
  endfunction

  // Output monitor: half a cycle after each edge.
  initial begin
    int  exp_seq = 0, exp_beat = 0;
    bit  ph1 = 0, ph2 = 0, prev_nonlast = 0, prev_last = 0;
    forever begin
      @(negedge clk); #1;
      if (rst) begin
        ph1 = 0; ph2 = 0; prev_nonlast = 0; prev_last = 0;
      end else begin
        if (ph2) check(!rd_valid, "R7", "valid two cycles after pause", DATA_W'(rd_valid), 0);
        if (prev_nonlast && !ph2) check(rd_valid, "R6", "valid inside block", DATA_W'(rd_valid), 1);
        if (prev_last) check(!rd_valid, "R8", "idle cycle after block", DATA_W'(rd_valid), 0);
        prev_nonlast = rd_valid && (exp_beat != BEATS - 1);
        prev_last    = rd_valid && (exp_beat == BEATS - 1);
        ph2 = ph1; ph1 = rd_pause;
        if (rd_valid) begin
          if (exp_seq >= NREQ) begin
            check(1'b0, "R5", "beat beyond last block", rd_data, 0);
          end else begin
            check(sent[exp_seq] == BEATS, "R9", "block shown before complete",
                  DATA_W'(sent[exp_seq]), DATA_W'(BEATS));
            check(rd_data[127:96] == 32'(exp_seq), "R5", "block order",
                  DATA_W'(rd_data[127:96]), DATA_W'(exp_seq));
            check(rd_data == beat_word(exp_seq, exp_beat), (exp_seq == 1) ? "R10" : "R4",
                  "beat data", rd_data, beat_word(exp_seq, exp_beat));
            exp_beat++;
            if (exp_beat == BEATS) begin
              exp_beat = 0; exp_seq++; del_cnt++;
            end
          end
        end
      end
    end
  end

  task automatic req_one();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    check(req_tag == SLOT_BITS'(acc_cnt % SLOTS), "R2", "tag order",
          DATA_W'(req_tag), DATA_W'(acc_cnt % SLOTS));
    acc_cnt++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_beats(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpl_valid = 1'b1;
      cpl_tag   = SLOT_BITS'(s % SLOTS);
      cpl_data  = beat_word(s, sent[s]);
      sent[s]++;
    end
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic send_junk(input int tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpl_valid = 1'b1;
      cpl_tag   = SLOT_BITS'(tag);
      cpl_data  = ~beat_word(tag, i);
    end
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic requester();
    while (acc_cnt < NREQ) begin
      @(negedge clk);
      check(req_ready == ((acc_cnt - del_cnt) < SLOTS), "R3", "ready vs outstanding",
            DATA_W'(req_ready), DATA_W'((acc_cnt - del_cnt) < SLOTS));
      if ($urandom % 4 != 0) begin
        req_valid = 1'b1;
        if (req_ready) begin
          check(req_tag == SLOT_BITS'(acc_cnt % SLOTS), "R2", "tag order",
                DATA_W'(req_tag), DATA_W'(acc_cnt % SLOTS));
          acc_cnt++;
        end
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic completer();
    int lo = 0, cur = -1, chunk = 0;
    while (lo < NREQ) begin
      @(negedge clk);
      cpl_valid = 1'b0;
      while (lo < NREQ && sent[lo] == BEATS) lo++;
      if (lo >= NREQ) break;
      if (cur < 0 || sent[cur] == BEATS || chunk == 0) begin
        int avail, s;
        avail = acc_cnt - lo;
        if (avail <= 0) continue;
        s = lo + int'($urandom % avail);
        cur = -1;
        for (int k = 0; k < avail; k++) begin
          int c;
          c = lo + ((s - lo + k) % avail);
          if (cur < 0 && sent[c] < BEATS) cur = c;
        end
        if (cur < 0) continue;
        chunk = 1 + int'($urandom % 96);
      end
      if ($urandom % 8 == 0) continue;
      cpl_valid = 1'b1;
      cpl_tag   = SLOT_BITS'(cur % SLOTS);
      cpl_data  = beat_word(cur, sent[cur]);
      sent[cur]++;
      chunk--;
    end
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic pauser();
    int left = 0;
    while (!all_done) begin
      @(negedge clk);
      if (left > 0) begin
        rd_pause = 1'b1; left--;
      end else if ($urandom % 24 == 0) begin
        rd_pause = 1'b1; left = int'($urandom % 12);
      end else begin
        rd_pause = ($urandom % 10 == 0);
      end
    end
    rd_pause = 1'b0;
  endtask

  initial begin
    int bad;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREQ; i++) sent[i] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    check(req_ready == 1'b1, "R1", "ready after reset", DATA_W'(req_ready), 1);
    check(rd_valid == 1'b0, "R1", "valid after reset", DATA_W'(rd_valid), 0);
    check(req_tag == '0, "R1", "tag after reset", DATA_W'(req_tag), 0);

    // Younger block complete first, stray beats to it, older block held back.
    req_one();
    req_one();
    send_beats(1, BEATS);
    send_junk(1, 5);
    send_beats(0, BEATS - 1);
    bad = 0;
    repeat (8) begin
      @(negedge clk); #1;
      if (rd_valid) bad++;
    end
    check(bad == 0, "R9", "no output while head incomplete", DATA_W'(bad), 0);
    send_beats(0, 1);
    while (del_cnt < 2 && cyc < WDOG) @(negedge clk);

    // Fill every slot with no completions.
    for (int i = 0; i < SLOTS; i++) req_one();
    @(negedge clk); #1;
    check(req_ready == 1'b0, "R3", "ready low when full", DATA_W'(req_ready), 0);

    fork
      requester();
      completer();
      pauser();
    join_none

    while (del_cnt < NREQ && cyc < WDOG) @(negedge clk);
    repeat (10) @(negedge clk);
    all_done = 1'b1;
    if (cyc >= WDOG) begin
      checks++; errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d blocks", del_cnt, NREQ);
    end
    check(del_cnt == NREQ, "R5", "all blocks delivered", DATA_W'(del_cnt), DATA_W'(NREQ));
    check(req_ready == 1'b1, "R3", "ready after drain", DATA_W'(req_ready), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule